// File: doc/BRIEF.md
# SPI Master Chip-Select Sequencer

This block sequences the select lines of an SPI master that talks to up to four peripherals, each behind its own active-low select output. Software writes a transmit word with a peripheral code into a one-word holding buffer. The block then drives the chosen select line low, asks a separate shift engine to move the word through a start/done handshake, and releases the line afterwards. Configuration inputs set how long the select lines rest between two selections and how long a select stays low after a transfer. A per-line keep bit lets a select stay low across transfers until a different peripheral is addressed.

A shared slave-select input watches for another master on the bus. When the block acts as master and that input is seen low, the block records a sticky mode-fault flag and disables itself. It stays disabled until software enables it again. A configuration bit turns this detection off.

Top module: `spi_cs_seq`

## Requirements
- R1: After reset all select outputs are high, `tx_empty` is 1, `mode_fault` is 0, `enabled` is 0 and `eng_start` is 0.
- R2: While enabled, a pulse on `tx_wr` when `tx_empty` is 1 loads the word, and `tx_empty` reads 0 in the cycle after the write.
- R3: Each accepted word produces exactly one `eng_start` pulse. While it is high, only the select line whose index equals `tx_pcs` is low, and `eng_data` equals the written word.
- R4: With the line's keep bit at 0, the select stays low for exactly max(`dly_xfer`,1) cycles after the cycle in which `eng_done` is sampled high, and is then released.
- R5: With the line's keep bit (`keep_sel[i]` for select i) at 1, the select stays low after the transfer. A new word for the same code starts without any release.
- R6: When a select is held and a word for a different code arrives, all selects are high for exactly max(`dly_sel`,1) cycles before the new select goes low.
- R7: When a select has been released and the next word is already waiting, the new select goes low after max(`dly_sel`,1)+1 cycles with all selects high. This holds even for the same code.
- R8: At most one select output is low in any cycle.
- R9: When the block is enabled, `master_mode` is 1, `mfd_dis` is 0 and `ssn_in` is low, `mode_fault` goes to 1 and `enabled` to 0 within three cycles. `ssn_in` passes a two-flop synchronizer first.
- R10: `mode_fault` stays 1 until a `stat_rd` pulse clears it. A `stat_rd` in the same cycle as a new fault leaves it at 1.
- R11: With `mfd_dis` at 1, or `master_mode` at 0, a low `ssn_in` sets no fault and leaves the block enabled.
- R12: While disabled, all selects are high, `tx_empty` is 1 and transmit writes are ignored. `en_clr` disables the block, `en_set` enables it, and `en_clr` wins if both arrive together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_set | input | 1 | Enable pulse |
| en_clr | input | 1 | Disable pulse |
| master_mode | input | 1 | Block acts as bus master |
| mfd_dis | input | 1 | Turns mode-fault detection off |
| keep_sel | input | NCS | Per-line keep-asserted bits |
| dly_sel | input | DLY_W | Rest cycles between selections |
| dly_xfer | input | DLY_W | Select hold cycles after a transfer |
| tx_wr | input | 1 | Transmit write strobe |
| tx_pcs | input | PCS_W | Target peripheral code |
| tx_data | input | DATA_W | Transmit word |
| tx_empty | output | 1 | Holding buffer can take a word |
| stat_rd | input | 1 | Status read pulse, clears the fault flag |
| mode_fault | output | 1 | Sticky mode-fault flag |
| enabled | output | 1 | Block is enabled |
| ssn_in | input | 1 | Shared slave-select input, active low |
| sel_n | output | NCS | Active-low select outputs |
| eng_start | output | 1 | One-cycle start pulse to the shift engine |
| eng_data | output | DATA_W | Word for the shift engine |
| eng_done | input | 1 | Shift engine finished the word |

## Verification
The bench builds the block with four select lines, 8-bit words and a 4-bit delay width (DLY_W=4). With the narrow delay fields, both delay values and the zero-treated-as-one corner can be tried within a few dozen cycles per scenario. Four lines allow a held select to be followed by a switch to another line, and a released line to be selected again. They also let the one-hot low pattern be checked against every code used.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_START,
        ST_BUSY,
        ST_TAIL
    } seq_state_e;
endpackage

// File: rtl/spi_cs_sync.sv
module spi_cs_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/spi_cs_fault.sv
module spi_cs_fault (
    input  logic clk,
    input  logic rst_n,
    input  logic ssn_sync,
    input  logic master_mode,
    input  logic mfd_dis,
    input  logic en_set,
    input  logic en_clr,
    input  logic stat_rd,
    output logic enabled,
    output logic mode_fault
);
    typedef struct packed {
        logic en;
        logic mf;
    } flt_t;

    flt_t f_d, f_q;
    logic fault_evt;

    always_comb begin
        f_d       = f_q;
        fault_evt = f_q.en & master_mode & ~mfd_dis & ~ssn_sync;
        if (fault_evt)   f_d.en = 1'b0;
        else if (en_clr) f_d.en = 1'b0;
        else if (en_set) f_d.en = 1'b1;
        if (fault_evt)    f_d.mf = 1'b1;
        else if (stat_rd) f_d.mf = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign enabled    = f_q.en;
    assign mode_fault = f_q.mf;
endmodule

// File: rtl/spi_cs_delay.sv
module spi_cs_delay #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)                    cnt_d = load_val;
        else if (run && cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/spi_cs_decode.sv
module spi_cs_decode #(
    parameter int NCS   = 4,
    parameter int PCS_W = 2
) (
    input  logic [PCS_W-1:0] pcs,
    input  logic             active,
    output logic [NCS-1:0]   sel_n
);
    for (genvar i = 0; i < NCS; i++) begin : g_line
        assign sel_n[i] = ~(active && (pcs == PCS_W'(i)));
    end
endmodule

// File: rtl/spi_cs_seq.sv
module spi_cs_seq
    import spi_cs_pkg::*;
#(
    parameter int NCS    = 4,
    parameter int DATA_W = 8,
    parameter int DLY_W  = 8,
    localparam int PCS_W = (NCS > 1) ? $clog2(NCS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_set,
    input  logic              en_clr,
    input  logic              master_mode,
    input  logic              mfd_dis,
    input  logic [NCS-1:0]    keep_sel,
    input  logic [DLY_W-1:0]  dly_sel,
    input  logic [DLY_W-1:0]  dly_xfer,
    input  logic              tx_wr,
    input  logic [PCS_W-1:0]  tx_pcs,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_empty,
    input  logic              stat_rd,
    output logic              mode_fault,
    output logic              enabled,
    input  logic              ssn_in,
    output logic [NCS-1:0]    sel_n,
    output logic              eng_start,
    output logic [DATA_W-1:0] eng_data,
    input  logic              eng_done
);
    typedef struct packed {
        seq_state_e        st;
        logic [PCS_W-1:0]  pcs;
        logic              held;
        logic              bvalid;
        logic [PCS_W-1:0]  bpcs;
        logic [DATA_W-1:0] bdata;
        logic [DATA_W-1:0] data;
    } seq_t;

    seq_t s_d, s_q;
    logic             ssn_sync;
    logic             dly_load;
    logic [DLY_W-1:0] dly_val;
    logic             dly_run;
    logic             dly_exp;
    logic             sel_act;

    function automatic logic [DLY_W-1:0] load_of(input logic [DLY_W-1:0] v);
        return (v == '0) ? '0 : v - 1'b1;
    endfunction

    spi_cs_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ssn_in),
        .q     (ssn_sync)
    );

    spi_cs_fault u_fault (
        .clk         (clk),
        .rst_n       (rst_n),
        .ssn_sync    (ssn_sync),
        .master_mode (master_mode),
        .mfd_dis     (mfd_dis),
        .en_set      (en_set),
        .en_clr      (en_clr),
        .stat_rd     (stat_rd),
        .enabled     (enabled),
        .mode_fault  (mode_fault)
    );

    spi_cs_delay #(.W(DLY_W)) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (dly_load),
        .load_val (dly_val),
        .run      (dly_run),
        .expired  (dly_exp)
    );

    always_comb begin
        s_d      = s_q;
        dly_load = 1'b0;
        dly_val  = '0;
        dly_run  = (s_q.st == ST_GAP) || (s_q.st == ST_TAIL);

        if (tx_wr && enabled && !s_q.bvalid) begin
            s_d.bvalid = 1'b1;
            s_d.bpcs   = tx_pcs;
            s_d.bdata  = tx_data;
        end

        unique case (s_q.st)
            ST_IDLE: begin
                if (s_q.bvalid && enabled) begin
                    s_d.bvalid = 1'b0;
                    s_d.data   = s_q.bdata;
                    if (s_q.held && s_q.pcs == s_q.bpcs) begin
                        s_d.st = ST_START;
                    end else begin
                        s_d.st   = ST_GAP;
                        s_d.held = 1'b0;
                        s_d.pcs  = s_q.bpcs;
                        dly_load = 1'b1;
                        dly_val  = load_of(dly_sel);
                    end
                end
            end
            ST_GAP: begin
                if (dly_exp) s_d.st = ST_START;
            end
            ST_START: begin
                s_d.st = ST_BUSY;
            end
            ST_BUSY: begin
                if (eng_done) begin
                    s_d.st   = ST_TAIL;
                    dly_load = 1'b1;
                    dly_val  = load_of(dly_xfer);
                end
            end
            ST_TAIL: begin
                if (dly_exp) begin
                    s_d.st   = ST_IDLE;
                    s_d.held = keep_sel[s_q.pcs];
                end
            end
            default: s_d.st = ST_IDLE;
        endcase

        if (!enabled) begin
            s_d.st     = ST_IDLE;
            s_d.held   = 1'b0;
            s_d.bvalid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, default: '0};
        else        s_q <= s_d;
    end

    always_comb begin
        sel_act = enabled &&
                  ((s_q.st == ST_START) || (s_q.st == ST_BUSY) ||
                   (s_q.st == ST_TAIL)  || (s_q.st == ST_IDLE && s_q.held));
    end

    spi_cs_decode #(.NCS(NCS), .PCS_W(PCS_W)) u_dec (
        .pcs    (s_q.pcs),
        .active (sel_act),
        .sel_n  (sel_n)
    );

    assign tx_empty  = ~s_q.bvalid | ~enabled;
    assign eng_start = enabled && (s_q.st == ST_START);
    assign eng_data  = s_q.data;
endmodule

// File: rtl/spi_cs_seq_chk.sv
module spi_cs_seq_chk #(
    parameter int NCS = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCS-1:0] sel_n,
    input logic           tx_empty,
    input logic           tx_wr,
    input logic           enabled,
    input logic           mode_fault,
    input logic           stat_rd,
    input logic           eng_start
);
    a_r8_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~sel_n) <= 1);

    a_r3_start_has_select: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> $countones(~sel_n) == 1);

    a_r12_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !enabled |-> (&sel_n && tx_empty && !eng_start));

    a_r12_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && !enabled) |=> tx_empty);

    a_r10_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_fault && !stat_rd) |=> mode_fault);

    a_r9_fault_disables: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_fault) |-> !enabled);
endmodule

bind spi_cs_seq spi_cs_seq_chk #(.NCS(NCS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_n      (sel_n),
    .tx_empty   (tx_empty),
    .tx_wr      (tx_wr),
    .enabled    (enabled),
    .mode_fault (mode_fault),
    .stat_rd    (stat_rd),
    .eng_start  (eng_start)
);

// File: tb/spi_cs_seq_tb.sv
`timescale 1ns/1ps
module spi_cs_seq_tb;
    localparam int NCS = 4, DATA_W = 8, DLY_W = 4, PCS_W = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic en_set = 0, en_clr = 0, master_mode = 1, mfd_dis = 0;
    logic [NCS-1:0] keep_sel = '0;
    logic [DLY_W-1:0] dly_sel = '0, dly_xfer = '0;
    logic tx_wr = 0;
    logic [PCS_W-1:0] tx_pcs = '0;
    logic [DATA_W-1:0] tx_data = '0;
    logic tx_empty, stat_rd = 0, mode_fault, enabled, ssn_in = 1;
    logic [NCS-1:0] sel_n;
    logic eng_start, eng_done = 0;
    logic [DATA_W-1:0] eng_data;

    int errors = 0, checks = 0;
    int starts = 0, rel_cnt = 0, hi_run = 0, last_gap = 0, last_aft = 0, aft = 0, lat = 0;
    bit was_low = 0, counting = 0;
    logic [NCS-1:0] st_sel = '0;
    logic [DATA_W-1:0] st_data = '0;

    always #2.5 clk = ~clk;

    spi_cs_seq #(.NCS(NCS), .DATA_W(DATA_W), .DLY_W(DLY_W)) u_dut (.*);

    // Monitor and shift-engine model, all at the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (sel_n == '1) begin
                if (was_low) rel_cnt++;
                hi_run++;
                was_low = 0;
            end else begin
                if (!was_low) last_gap = hi_run;
                hi_run = 0;
                was_low = 1;
            end
            if (eng_done) begin
                eng_done = 0;
                counting = 1;
                aft = 0;
            end
            if (counting) begin
                if (sel_n != '1) aft++;
                else begin last_aft = aft; counting = 0; end
            end
            if (eng_start) begin
                starts++;
                st_sel = ~sel_n;
                st_data = eng_data;
                lat = 3;
            end else if (lat > 0) begin
                lat--;
                if (lat == 0) eng_done = 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_en;
        @(negedge clk) en_set = 1;
        @(negedge clk) en_set = 0;
    endtask

    task automatic do_write(input logic [PCS_W-1:0] p, input logic [DATA_W-1:0] d);
        @(negedge clk);
        tx_wr = 1; tx_pcs = p; tx_data = d;
        @(negedge clk);
        tx_wr = 0;
    endtask

    task automatic t_reset;
        chk(sel_n == '1, "R1 sel_n", int'(sel_n), 15);
        chk(tx_empty == 1, "R1 tx_empty", int'(tx_empty), 1);
        chk(mode_fault == 0, "R1 mode_fault", int'(mode_fault), 0);
        chk(enabled == 0 && eng_start == 0, "R1 enabled/start", int'(enabled), 0);
    endtask

    task automatic t_basic;
        int s0;
        keep_sel = '0; dly_sel = 2; dly_xfer = 5;
        s0 = starts;
        do_write(1, 8'hA5);
        chk(tx_empty == 0, "R2 tx_empty after write", int'(tx_empty), 0);
        cyc(30);
        chk(starts == s0 + 1, "R3 one start", starts - s0, 1);
        chk(st_sel == 4'b0010, "R3 select at start", int'(st_sel), 2);
        chk(st_data == 8'hA5, "R3 data", int'(st_data), 165);
        chk(last_aft == 5, "R4 tail length", last_aft, 5);
        chk(sel_n == '1, "R4 released", int'(sel_n), 15);
        dly_xfer = 0;
        do_write(2, 8'h3C);
        cyc(30);
        chk(last_aft == 1, "R4 zero tail is one", last_aft, 1);
        chk(st_sel == 4'b0100 && st_data == 8'h3C, "R3 second word", int'(st_sel), 4);
    endtask

    task automatic t_keep_switch;
        int s0, r0;
        keep_sel = 4'b0001; dly_sel = 3; dly_xfer = 2;
        do_write(0, 8'h11);
        cyc(30);
        chk(sel_n == 4'b1110, "R5 held after transfer", int'(sel_n), 14);
        s0 = starts; r0 = rel_cnt;
        do_write(0, 8'h22);
        cyc(30);
        chk(starts == s0 + 1 && st_data == 8'h22, "R5 same code restart", starts - s0, 1);
        chk(rel_cnt == r0, "R5 no release", rel_cnt - r0, 0);
        chk(sel_n == 4'b1110, "R5 still held", int'(sel_n), 14);
        do_write(3, 8'h33);
        cyc(30);
        chk(last_gap == 3, "R6 switch gap", last_gap, 3);
        chk(st_sel == 4'b1000, "R6 new select", int'(st_sel), 8);
        do_write(0, 8'h44);
        cyc(30);
        dly_sel = 0;
        do_write(2, 8'h55);
        cyc(30);
        chk(last_gap == 1, "R6 zero gap is one", last_gap, 1);
    endtask

    task automatic t_reselect;
        int s0;
        keep_sel = '0; dly_sel = 2; dly_xfer = 1;
        s0 = starts;
        do_write(2, 8'h66);
        while (starts == s0) @(negedge clk);
        do_write(2, 8'h77);
        cyc(40);
        chk(starts == s0 + 2, "R7 both words sent", starts - s0, 2);
        chk(last_gap == 3, "R7 reselect gap", last_gap, 3);
    endtask

    task automatic t_fault;
        int s0;
        ssn_in = 0;
        cyc(5);
        chk(mode_fault == 1, "R9 fault set", int'(mode_fault), 1);
        chk(enabled == 0, "R9 disabled", int'(enabled), 0);
        chk(sel_n == '1 && tx_empty == 1, "R12 quiet when disabled", int'(sel_n), 15);
        s0 = starts;
        do_write(1, 8'h99);
        chk(tx_empty == 1, "R12 write ignored", int'(tx_empty), 1);
        cyc(10);
        chk(starts == s0, "R12 no start", starts - s0, 0);
        cyc(3);
        chk(mode_fault == 1, "R10 sticky", int'(mode_fault), 1);
        ssn_in = 1;
        @(negedge clk) stat_rd = 1;
        @(negedge clk) stat_rd = 0;
        chk(mode_fault == 0, "R10 read clears", int'(mode_fault), 0);
        // Read in the same cycle as a new fault.
        ssn_in = 0;
        cyc(4);
        @(negedge clk) en_set = 1;
        @(negedge clk) begin en_set = 0; stat_rd = 1; end
        @(negedge clk) stat_rd = 0;
        chk(mode_fault == 1, "R10 read vs new fault", int'(mode_fault), 1);
        chk(enabled == 0, "R9 disabled again", int'(enabled), 0);
        ssn_in = 1;
        cyc(3);
        @(negedge clk) stat_rd = 1;
        @(negedge clk) stat_rd = 0;
        chk(mode_fault == 0, "R10 cleared", int'(mode_fault), 0);
    endtask

    task automatic t_mfdis;
        mfd_dis = 1;
        pulse_en;
        ssn_in = 0;
        cyc(6);
        chk(enabled == 1 && mode_fault == 0, "R11 detection off", int'(mode_fault), 0);
        mfd_dis = 0; master_mode = 0;
        cyc(6);
        chk(enabled == 1 && mode_fault == 0, "R11 not master", int'(mode_fault), 0);
        ssn_in = 1;
        cyc(3);
        master_mode = 1;
    endtask

    task automatic t_disable_held;
        int s0;
        keep_sel = 4'b0001; dly_sel = 1; dly_xfer = 1;
        do_write(0, 8'hC3);
        cyc(25);
        chk(sel_n == 4'b1110, "R5 held before disable", int'(sel_n), 14);
        @(negedge clk) begin en_clr = 1; en_set = 1; end
        @(negedge clk) begin en_clr = 0; en_set = 0; end
        chk(enabled == 0, "R12 clear wins", int'(enabled), 0);
        chk(sel_n == '1, "R12 release on disable", int'(sel_n), 15);
        pulse_en;
        s0 = starts;
        do_write(0, 8'h5A);
        cyc(25);
        chk(starts == s0 + 1 && st_data == 8'h5A, "R12 works after enable", starts - s0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset;
        pulse_en;
        t_basic;
        t_keep_switch;
        t_reselect;
        t_fault;
        t_mfdis;
        t_disable_held;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule